// File: doc/BRIEF.md
# Pipelined Converter Self-Calibration Sequencer

This controller runs the self-calibration of a multi-stage pipelined analog-to-digital converter. A calibration request on `cal_req` is qualified on falling clock edges. Once it qualifies, the block raises `busy`, shorts both analog inputs to the common-mode level through `input_short`, and marks the converter output invalid. It then works through the stages that need correction. The order is back to front: the stage just ahead of the uncalibrated tail goes first, then each earlier stage, and the sample-and-hold comes last. Each step uses the part of the pipeline behind it, which has already been corrected.

Each step has a measurement window of `WIN_CYCLES` clocks followed by one store clock. In the store clock, the measurement word returned by the analog side is written into a small coefficient memory at the address of that stage. The correction datapath reads this memory through a combinational port. With the default parameters a full run lasts 4 × 372500 = 1,490,000 clocks. A simulation can shrink `WIN_CYCLES` to keep runs short.

An active-low asynchronous reset aborts any run, wipes every coefficient and returns the sequencer to idle. The output stays flagged invalid until a later calibration completes. All pins are plain control or status signals. The measurement word is sampled without a handshake in the store cycle, so no back-pressure exists at the edge of this block.

Top module: `cal_seq_ctrl`

## Requirements
- R1: A run starts only after `cal_req` is seen high on QUAL_EDGES (default 3) consecutive falling clock edges while `rst_n` is high. `busy` rises at the first rising edge after the qualifying falling edge. A request high on fewer falling edges starts nothing.
- R2: `busy` stays high from the start until the last coefficient is stored, then falls. One run lasts exactly N_STEPS × (WIN_CYCLES + 1) clocks.
- R3: While busy, `stage_sel` steps through N_STEPS−1 down to 0, where 0 is the sample-and-hold and N_STEPS−1 is the rearmost calibrated stage. Each value is held for WIN_CYCLES measurement clocks plus one store clock. While idle, `stage_sel` is 0.
- R4: `coef_we` is high for exactly one clock at the end of each step. In that clock, `coef_waddr` equals `stage_sel` and `coef_wdata` equals `meas_word`. At all other times `coef_we` is low.
- R5: `rst_n` low returns the block to idle at once, without waiting for a clock: `busy` and `input_short` are low. While reset is held, every coefficient entry reads zero.
- R6: `input_short` is high exactly when `busy` is high.
- R7: `data_invalid` is high while busy. It is also high from any reset until a run completes, and low once a run has finished.
- R8: A request that arrives or stays high while busy is ignored. A new run needs `cal_req` to be seen low on a falling edge while idle, and then high again for the qualification count.
- R9: `coef_rdata` returns, in the same cycle, the entry stored at `coef_raddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous reset, active low; also clears coefficients |
| cal_req | input | 1 | Calibration request, qualified on falling edges |
| meas_word | input | COEF_W | Measurement returned by the analog side for the current stage |
| coef_raddr | input | SEL_W | Coefficient read address for the correction datapath |
| busy | output | 1 | Calibration in progress |
| input_short | output | 1 | Enables the switches tying both analog inputs to common mode |
| stage_sel | output | SEL_W | Stage under measurement (0 = sample-and-hold) |
| coef_we | output | 1 | Coefficient write strobe |
| coef_waddr | output | SEL_W | Coefficient write address |
| coef_wdata | output | COEF_W | Coefficient write data |
| data_invalid | output | 1 | Conversion results must be disregarded |
| coef_rdata | output | COEF_W | Coefficient read data |

## Verification
The assertions assume that `cal_req` changes away from falling edges. They also assume that `rst_n` is asserted and released between clock edges, so the qualifier's falling-edge samples and the sequencer's rising-edge samples always see settled values. They further assume that `meas_word` is stable around the rising edge that ends a step. The stimulus meets all of this by driving every input 1.5 ns after a rising edge, half a nanosecond before the falling edge. Reset is applied and lifted at that same point in the cycle. A behavioural model updated on both clock edges predicts every output each cycle. The model's predictions cover short requests, held and toggled requests during a run, and an abort in mid-sequence.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_MEAS  = 2'd1,
    CS_STORE = 2'd2
  } cal_state_e;

  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/cal_req_qual.sv
module cal_req_qual #(
  parameter int QUAL_EDGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_req,
  input  logic busy,
  output logic qual_ok
);

  localparam int QW = $clog2(QUAL_EDGES + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_EDGES);

  logic [QW-1:0] hi_cnt;
  logic          armed;

  // Sampled on falling edges; a request seen while busy disarms until it drops.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      armed  <= 1'b1;
    end else if (busy) begin
      hi_cnt <= '0;
      armed  <= 1'b0;
    end else if (!cal_req) begin
      hi_cnt <= '0;
      armed  <= 1'b1;
    end else if (armed && hi_cnt != QMAX) begin
      hi_cnt <= hi_cnt + 1'b1;
    end
  end

  assign qual_ok = armed && (hi_cnt == QMAX);

  assert_no_qual_after_busy_R8: assert property (
    @(negedge clk) disable iff (!rst_n) busy |=> !qual_ok
  ) else $error("qualifier armed while sequencer busy");

endmodule

// File: rtl/cal_step_fsm.sv
module cal_step_fsm
  import cal_seq_pkg::*;
#(
  parameter int N_STEPS    = 4,
  parameter int WIN_CYCLES = 372499,
  parameter int COEF_W     = 16,
  parameter int SEL_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qual_ok,
  input  logic [COEF_W-1:0] meas_word,
  output logic              busy,
  output logic [SEL_W-1:0]  stage_sel,
  output logic              coef_we,
  output logic [SEL_W-1:0]  coef_waddr,
  output logic [COEF_W-1:0] coef_wdata,
  output logic              cal_done
);

  localparam int CNT_W = $clog2(WIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(WIN_CYCLES - 1);
  localparam logic [SEL_W-1:0] STEP_LAST = SEL_W'(N_STEPS - 1);

  cal_state_e       state;
  logic [SEL_W-1:0] step;
  logic [CNT_W-1:0] win_cnt;
  logic [SEL_W-1:0] cur_stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= CS_IDLE;
      step     <= '0;
      win_cnt  <= '0;
      cal_done <= 1'b0;
    end else begin
      unique case (state)
        CS_IDLE: begin
          if (qual_ok) begin
            state   <= CS_MEAS;
            step    <= '0;
            win_cnt <= '0;
          end
        end
        CS_MEAS: begin
          if (win_cnt == WIN_LAST) state <= CS_STORE;
          else                     win_cnt <= win_cnt + 1'b1;
        end
        CS_STORE: begin
          if (step == STEP_LAST) begin
            state    <= CS_IDLE;
            cal_done <= 1'b1;
          end else begin
            step    <= step + 1'b1;
            win_cnt <= '0;
            state   <= CS_MEAS;
          end
        end
        default: state <= CS_IDLE;
      endcase
    end
  end

  // Rearmost calibrated stage first, sample-and-hold (0) last.
  assign cur_stage  = STEP_LAST - step;
  assign busy       = (state != CS_IDLE);
  assign stage_sel  = busy ? cur_stage : '0;
  assign coef_we    = (state == CS_STORE);
  assign coef_waddr = cur_stage;
  assign coef_wdata = meas_word;

  assert_window_bound_R3: assert property (
    @(posedge clk) disable iff (!rst_n) state == CS_MEAS |-> win_cnt <= WIN_LAST
  ) else $error("measurement counter past window");

endmodule

// File: rtl/cal_coef_store.sv
module cal_coef_store #(
  parameter int N_ENTRY = 4,
  parameter int COEF_W  = 16,
  parameter int SEL_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEL_W-1:0]  waddr,
  input  logic [COEF_W-1:0] wdata,
  input  logic [SEL_W-1:0]  raddr,
  output logic [COEF_W-1:0] rdata
);

  logic [COEF_W-1:0] rd_vec [N_ENTRY];

  for (genvar i = 0; i < N_ENTRY; i++) begin : g_ent
    logic [COEF_W-1:0] entry_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          entry_q <= '0;
      else if (we && waddr == SEL_W'(i))   entry_q <= wdata;
    end
    assign rd_vec[i] = entry_q;
  end

  assign rdata = (int'(raddr) < N_ENTRY) ? rd_vec[raddr] : '0;

  assert_write_in_range_R4: assert property (
    @(posedge clk) disable iff (!rst_n) we |-> int'(waddr) < N_ENTRY
  ) else $error("coefficient write outside memory");

endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
  import cal_seq_pkg::*;
#(
  parameter int N_STEPS    = 4,
  parameter int WIN_CYCLES = 372499,
  parameter int COEF_W     = 16,
  parameter int QUAL_EDGES = 3,
  localparam int SEL_W     = sel_width(N_STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_req,
  input  logic [COEF_W-1:0] meas_word,
  input  logic [SEL_W-1:0]  coef_raddr,
  output logic              busy,
  output logic              input_short,
  output logic [SEL_W-1:0]  stage_sel,
  output logic              coef_we,
  output logic [SEL_W-1:0]  coef_waddr,
  output logic [COEF_W-1:0] coef_wdata,
  output logic              data_invalid,
  output logic [COEF_W-1:0] coef_rdata
);

  logic qual_ok;
  logic cal_done;

  cal_req_qual #(.QUAL_EDGES(QUAL_EDGES)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .cal_req (cal_req),
    .busy    (busy),
    .qual_ok (qual_ok)
  );

  cal_step_fsm #(
    .N_STEPS    (N_STEPS),
    .WIN_CYCLES (WIN_CYCLES),
    .COEF_W     (COEF_W),
    .SEL_W      (SEL_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .qual_ok    (qual_ok),
    .meas_word  (meas_word),
    .busy       (busy),
    .stage_sel  (stage_sel),
    .coef_we    (coef_we),
    .coef_waddr (coef_waddr),
    .coef_wdata (coef_wdata),
    .cal_done   (cal_done)
  );

  cal_coef_store #(
    .N_ENTRY (N_STEPS),
    .COEF_W  (COEF_W),
    .SEL_W   (SEL_W)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (coef_we),
    .waddr (coef_waddr),
    .wdata (coef_wdata),
    .raddr (coef_raddr),
    .rdata (coef_rdata)
  );

  assign input_short  = busy;
  assign data_invalid = busy || !cal_done;

  assert_start_qualified_R1: assert property (
    @(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(qual_ok)
  ) else $error("run started without a qualified request");

  assert_single_strobe_R4: assert property (
    @(posedge clk) disable iff (!rst_n) coef_we |=> !coef_we
  ) else $error("write strobe longer than one clock");

  assert_stage_descends_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && stage_sel != $past(stage_sel))
        |-> (stage_sel == $past(stage_sel) - 1'b1) && $past(coef_we)
  ) else $error("stage order broken");

  assert_end_after_last_store_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(coef_we) && $past(coef_waddr) == '0
  ) else $error("busy fell before sample-and-hold coefficient stored");

  assert_invalid_while_busy_R7: assert property (
    @(posedge clk) disable iff (!rst_n) busy |-> data_invalid
  ) else $error("output marked valid during calibration");

endmodule

// File: tb/cal_seq_ctrl_test.sv
module cal_seq_ctrl_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NS  = 4;
  localparam int WIN = 6;
  localparam int CW  = 16;
  localparam int SW  = 2;
  localparam int RUN = NS * (WIN + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cal_req = 1'b0;
  logic [CW-1:0] meas_word = 16'h1234;
  logic [SW-1:0] coef_raddr = '0;
  logic          busy, input_short, coef_we, data_invalid;
  logic [SW-1:0] stage_sel, coef_waddr;
  logic [CW-1:0] coef_wdata, coef_rdata;

  int  total = 0;
  int  bad = 0;
  int  cycles = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  cal_seq_ctrl #(.N_STEPS(NS), .WIN_CYCLES(WIN), .COEF_W(CW), .QUAL_EDGES(3)) uut (
    .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .meas_word(meas_word),
    .coef_raddr(coef_raddr), .busy(busy), .input_short(input_short),
    .stage_sel(stage_sel), .coef_we(coef_we), .coef_waddr(coef_waddr),
    .coef_wdata(coef_wdata), .data_invalid(data_invalid), .coef_rdata(coef_rdata)
  );

  // Behavioural reference model
  int m_state, m_step, m_cnt, m_n;
  bit m_arm, m_done;
  int m_coef [NS];

  task automatic model_reset();
    m_state = 0; m_step = 0; m_cnt = 0; m_n = 0; m_arm = 1'b1; m_done = 1'b0;
    foreach (m_coef[i]) m_coef[i] = 0;
  endtask

  initial model_reset();

  always @(negedge clk) if (rst_n) begin
    if (m_state != 0)           begin m_n = 0; m_arm = 1'b0; end
    else if (!cal_req)          begin m_n = 0; m_arm = 1'b1; end
    else if (m_arm && m_n < 3)  m_n++;
  end

  always @(posedge clk) if (rst_n) begin
    case (m_state)
      0: if (m_arm && m_n == 3) begin m_state = 1; m_step = 0; m_cnt = 0; end
      1: if (m_cnt == WIN - 1) m_state = 2; else m_cnt++;
      default: begin
        m_coef[NS-1-m_step] = int'(meas_word);
        if (m_step == NS - 1) begin m_state = 0; m_done = 1'b1; end
        else begin m_step++; m_cnt = 0; m_state = 1; end
      end
    endcase
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison, 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (!finished) begin
      chk("R2", "busy", busy, (m_state != 0));
      chk("R6", "input_short", input_short, (m_state != 0));
      chk("R3", "stage_sel", stage_sel, (m_state != 0) ? NS - 1 - m_step : 0);
      chk("R4", "coef_we", coef_we, (m_state == 2));
      if (m_state == 2) begin
        chk("R4", "coef_waddr", coef_waddr, NS - 1 - m_step);
        chk("R4", "coef_wdata", coef_wdata, meas_word);
      end
      chk("R7", "data_invalid", data_invalid, (m_state != 0) || !m_done);
      chk("R9", "coef_rdata", coef_rdata, m_coef[coef_raddr]);
    end
  end

  // Free-running measurement word and read-address sweep
  always @(posedge clk) begin
    #1.5;
    meas_word  = meas_word * 16'd25173 + 16'd13849;
    coef_raddr = coef_raddr + 1'b1;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1.5;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
      finish_run();
    end
  end

  initial begin
    tick(3);
    chk("R5", "busy in reset", busy, 0);
    chk("R7", "invalid in reset", data_invalid, 1);
    chk("R5", "rdata in reset", coef_rdata, 0);
    rst_n = 1'b1;

    // R1: request high on only two falling edges
    cal_req = 1'b1;
    tick(2);
    cal_req = 1'b0;
    tick(4);
    chk("R1", "busy after short request", busy, 0);

    // R1/R2: full run
    cal_req = 1'b1;
    tick(2);
    chk("R1", "busy before third edge", busy, 0);
    tick(1);
    chk("R1", "busy after third edge", busy, 1);
    chk("R3", "first stage", stage_sel, NS - 1);
    tick(RUN - 1);
    chk("R2", "busy at last cycle", busy, 1);
    chk("R3", "last stage", stage_sel, 0);
    tick(1);
    chk("R2", "busy after run", busy, 0);
    chk("R7", "valid after run", data_invalid, 0);

    // R8: request still high after the run
    tick(8);
    chk("R8", "held request ignored", busy, 0);

    // Rearm, then toggle the request while busy
    cal_req = 1'b0;
    tick(1);
    cal_req = 1'b1;
    tick(3);
    chk("R8", "rearmed start", busy, 1);
    tick(5);
    cal_req = 1'b0;
    tick(2);
    cal_req = 1'b1;
    tick(RUN + 4);
    chk("R8", "toggle during run ignored", busy, 0);

    // R5: abort in mid-sequence
    cal_req = 1'b0;
    tick(1);
    cal_req = 1'b1;
    tick(3);
    tick(WIN + 2);
    chk("R3", "second stage", stage_sel, NS - 2);
    rst_n = 1'b0;
    model_reset();
    #0.3;
    chk("R5", "busy right after reset", busy, 0);
    chk("R5", "short right after reset", input_short, 0);
    chk("R7", "invalid right after reset", data_invalid, 1);
    for (int k = 0; k < NS; k++) begin
      tick(1);
      chk("R5", "rdata cleared", coef_rdata, 0);
    end
    rst_n = 1'b1;
    tick(RUN + 6);
    chk("R7", "valid after recovery run", data_invalid, 0);
    chk("R2", "idle after recovery run", busy, 0);
    finish_run();
  end

endmodule